// File: doc/BRIEF.md
# Branch Target Permission Checker

This block decides whether a branch is allowed to land at a given halfword inside a 256-bit instruction block of eight 32-bit slots. The last slot of the block can act as a control word. When it does, it assigns each of the other seven slots a two-bit target code. Each code limits which branch kinds may land in that slot and whether the odd halfword may be a target.

When the control word is missing, or has been disabled because the previous block marked the last slot as a pair of 16-bit instructions, a per-program policy input decides the outcome. The branch unit presents one request per strobe. One cycle later the block returns a permit bit together with a two-bit reason code.

Top module: `btpc_top`

## Requirements
- R1: A response (`resp_valid` high, with new `permit` and `reason`) appears exactly one cycle after each cycle with `req_valid` high. In any other cycle `resp_valid` is low and `permit` and `reason` keep their last values.
- R2: The control word is the low 32 bits of `block_in`, which form slot 7 (slot 0 is `block_in[255:224]`). It is valid only when its two most significant bits are 01. Slot k's code lies in control-word bits [29-2k : 28-2k], where bit 29-2k is the upper bit of the code.
- R3: Reason encoding is 00 ok, 01 bad-kind, 10 bad-halfword, 11 forbidden. `permit` is 1 exactly when the reason is ok. Code 00 permits both branch kinds at the even halfword.
- R4: Code 01 permits a local conditional jump (`br_call`=0) at the even halfword. It denies a call (`br_call`=1) with reason bad-kind.
- R5: Code 10 permits both branch kinds at both the even and the odd halfword.
- R6: Code 11 denies every target in the slot with reason forbidden, at either halfword and for either kind.
- R7: An odd halfword target (`tgt_hw[0]`=1) in a slot coded 00 or 01 is denied with reason bad-halfword. The priority order is forbidden, then bad-halfword, then bad-kind.
- R8: With a valid control word, any target inside slot 7 itself is denied with reason forbidden.
- R9: When `prev_pair_last` is 1, a leading 01 in slot 7 is not treated as a control word, and the policy fallback applies.
- R10: Without a valid control word, `policy_open`=1 permits the branch with reason ok. `policy_open`=0 denies it with reason forbidden. Target and kind are not considered.
- R11: While `rst_n` is low, `resp_valid`, `permit` and `reason` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| block_in | input | 256 | Instruction block; slot 0 in the top bits, control slot in the low bits |
| tgt_hw | input | 4 | Target halfword offset; bits [3:1] slot, bit 0 odd half |
| br_call | input | 1 | 0 local conditional jump, 1 call or other branch |
| prev_pair_last | input | 1 | Previous block marked slot 7 as two 16-bit instructions |
| policy_open | input | 1 | Per-program fallback: 1 allow, 0 deny |
| resp_valid | output | 1 | Response strobe |
| permit | output | 1 | Branch allowed |
| reason | output | 2 | Decision reason code |

## Verification
The bench builds the block with its default parameters: eight slots of 32 bits, which gives a 4-bit halfword offset. With these values every slot index, including the control slot, and both halfwords can be reached with a small number of directed requests. One block that mixes all four codes is swept over all sixteen halfwords and both branch kinds, and the results are compared against a bench-side model of the rules. Separate scenarios cover the priority between reasons, the disabled control word, the policy fallback and the holding of outputs between requests.

// File: rtl/btpc_pkg.sv
package btpc_pkg;

    typedef enum logic [1:0] {
        RSN_OK     = 2'b00,
        RSN_KIND   = 2'b01,
        RSN_HALF   = 2'b10,
        RSN_FORBID = 2'b11
    } reason_e;

    typedef enum logic [1:0] {
        TC_ANY   = 2'b00,
        TC_LOCAL = 2'b01,
        TC_PAIR  = 2'b10,
        TC_NONE  = 2'b11
    } tcode_e;

    typedef struct packed {
        logic    vld;
        logic    ok;
        reason_e rsn;
    } resp_t;

endpackage

// File: rtl/btpc_cw_locate.sv
module btpc_cw_locate
    import btpc_pkg::*;
#(
    parameter int SLOT_W  = 32,
    parameter int N_SLOTS = 8
) (
    input  logic [SLOT_W*N_SLOTS-1:0] block_in,
    input  logic                      prev_pair_last,
    output logic                      cw_valid,
    output logic [N_SLOTS-1:0][1:0]   codes
);
    localparam int CODE_BITS = 2 * (N_SLOTS - 1);
    localparam int REST_W    = SLOT_W - 2 - CODE_BITS;

    logic [SLOT_W-1:0] cw;
    assign cw = block_in[SLOT_W-1:0];

    // leading pair 01 marks a control word unless the prior block claimed the slot
    assign cw_valid = (cw[SLOT_W-1 -: 2] == 2'b01) && !prev_pair_last;

    for (genvar k = 0; k < N_SLOTS - 1; k++) begin : g_code
        assign codes[k] = cw[SLOT_W-3-2*k -: 2];
    end
    // the control slot itself is never a legal landing point
    assign codes[N_SLOTS-1] = TC_NONE;

    logic unused_payload;
    assign unused_payload = ^{block_in[SLOT_W*N_SLOTS-1:SLOT_W], cw[REST_W-1:0]};

endmodule

// File: rtl/btpc_slot_rule.sv
module btpc_slot_rule
    import btpc_pkg::*;
(
    input  logic [1:0] code,
    input  logic       odd_half,
    input  logic       is_call,
    output logic [1:0] verdict
);
    tcode_e  tc;
    reason_e rsn;

    assign tc = tcode_e'(code);

    always_comb begin
        rsn = RSN_OK;
        if (tc == TC_NONE) begin
            rsn = RSN_FORBID;
        end else if (odd_half && tc != TC_PAIR) begin
            rsn = RSN_HALF;
        end else if (tc == TC_LOCAL && is_call) begin
            rsn = RSN_KIND;
        end
    end

    assign verdict = rsn;

    // R7: odd halfword never passes unless slot holds a 16-bit pair
    always_comb begin
        p_odd_needs_pair_r7: assert (!(odd_half && code != TC_PAIR) || verdict != RSN_OK);
    end

endmodule

// File: rtl/btpc_top.sv
module btpc_top
    import btpc_pkg::*;
#(
    parameter int SLOT_W  = 32,
    parameter int N_SLOTS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [SLOT_W*N_SLOTS-1:0] block_in,
    input  logic [$clog2(N_SLOTS*2)-1:0] tgt_hw,
    input  logic                      br_call,
    input  logic                      prev_pair_last,
    input  logic                      policy_open,
    output logic                      resp_valid,
    output logic                      permit,
    output logic [1:0]                reason
);
    localparam int HW_W  = $clog2(N_SLOTS * 2);
    localparam int SEL_W = HW_W - 1;

    logic                    cw_valid;
    logic [N_SLOTS-1:0][1:0] codes;
    logic [SEL_W-1:0]        slot_sel;
    logic [1:0]              slot_code;
    logic [1:0]              rule_rsn;
    reason_e                 eval_rsn;

    resp_t resp_d, resp_q;

    btpc_cw_locate #(.SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) i_locate (
        .block_in       (block_in),
        .prev_pair_last (prev_pair_last),
        .cw_valid       (cw_valid),
        .codes          (codes)
    );

    assign slot_sel  = tgt_hw[HW_W-1:1];
    assign slot_code = codes[slot_sel];

    btpc_slot_rule i_rule (
        .code     (slot_code),
        .odd_half (tgt_hw[0]),
        .is_call  (br_call),
        .verdict  (rule_rsn)
    );

    always_comb begin
        if (cw_valid) begin
            eval_rsn = reason_e'(rule_rsn);
        end else begin
            eval_rsn = policy_open ? RSN_OK : RSN_FORBID;
        end
    end

    always_comb begin
        resp_d     = resp_q;
        resp_d.vld = req_valid;
        if (req_valid) begin
            resp_d.rsn = eval_rsn;
            resp_d.ok  = (eval_rsn == RSN_OK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '{vld: 1'b0, ok: 1'b0, rsn: RSN_OK};
        end else begin
            resp_q <= resp_d;
        end
    end

    assign resp_valid = resp_q.vld;
    assign permit     = resp_q.ok;
    assign reason     = resp_q.rsn;

    // R1: one response per strobe, one cycle later
    p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    p_hold_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(reason) && $stable(permit)));

    // R8: control slot is not a target
    p_cw_slot_denied_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cw_valid && slot_sel == SEL_W'(N_SLOTS - 1)) |=> (!permit && reason == RSN_FORBID));

    // R4: calls never land on local-only slots
    p_no_call_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cw_valid && br_call && slot_code == TC_LOCAL) |=> !permit);

    // R10: closed policy denies without a control word
    p_policy_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cw_valid && !policy_open) |=> (reason == RSN_FORBID && !permit));

    // R3: permit agrees with the ok reason on each response
    p_permit_reason_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (permit == (reason == RSN_OK)));

endmodule

// File: tb/test_btpc_top.sv
`timescale 1ns/1ps
module test_btpc_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic [255:0] block_in;
    logic [3:0]   tgt_hw;
    logic         br_call;
    logic         prev_pair_last;
    logic         policy_open;
    logic         resp_valid;
    logic         permit;
    logic [1:0]   reason;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    btpc_top i_btpc_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .block_in       (block_in),
        .tgt_hw         (tgt_hw),
        .br_call        (br_call),
        .prev_pair_last (prev_pair_last),
        .policy_open    (policy_open),
        .resp_valid     (resp_valid),
        .permit         (permit),
        .reason         (reason)
    );

    // codes[13:12] belongs to slot 0, codes[1:0] to slot 6
    function automatic logic [255:0] mk_block(input logic [1:0] lead, input logic [13:0] codes);
        return {{7{32'h8421_F00D}}, lead, codes, 16'h3C96};
    endfunction

    function automatic logic [1:0] model(input logic [255:0] blk, input int hw,
                                         input bit call, input bit prev, input bit pol);
        logic [31:0] cw;
        logic [1:0]  code;
        int          slot;
        cw = blk[31:0];
        if (cw[31:30] != 2'b01 || prev) return pol ? 2'd0 : 2'd3;
        slot = hw >> 1;
        if (slot == 7) return 2'd3;
        code = cw[29-2*slot -: 2];
        if (code == 2'b11) return 2'd3;
        if ((hw & 1) != 0 && code != 2'b10) return 2'd2;
        if (code == 2'b01 && call) return 2'd1;
        return 2'd0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [255:0] blk, input int hw, input bit call,
                          input bit prev, input bit pol, input logic [1:0] exp, input string tag);
        @(negedge clk);
        req_valid      = 1'b1;
        block_in       = blk;
        tgt_hw         = hw[3:0];
        br_call        = call;
        prev_pair_last = prev;
        policy_open    = pol;
        @(posedge clk);
        #1;
        check(resp_valid == 1'b1, {tag, " R1 resp_valid"}, resp_valid, 1);
        check(reason == exp, {tag, " reason"}, reason, exp);
        check(permit == (exp == 2'd0), {tag, " R3 permit"}, permit, exp == 2'd0);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; req_valid = 1'b1;
        block_in = mk_block(2'b01, 14'h0); tgt_hw = 0; br_call = 0;
        prev_pair_last = 0; policy_open = 1;
        repeat (3) @(posedge clk);
        #1;
        check(resp_valid == 0, "R11 resp_valid", resp_valid, 0);
        check(permit == 0, "R11 permit", permit, 0);
        check(reason == 0, "R11 reason", reason, 0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_code00;
        logic [255:0] b = mk_block(2'b01, 14'b00_11_11_11_11_11_00);
        do_req(b, 0,  0, 0, 0, 2'd0, "R3 any local slot0");
        do_req(b, 0,  1, 0, 0, 2'd0, "R3 any call slot0");
        do_req(b, 12, 1, 0, 0, 2'd0, "R2 any call slot6");
    endtask

    task automatic t_code01;
        logic [255:0] b = mk_block(2'b01, 14'b11_01_11_11_11_11_11);
        do_req(b, 2, 0, 0, 0, 2'd0, "R4 local ok");
        do_req(b, 2, 1, 0, 0, 2'd1, "R4 call bad-kind");
    endtask

    task automatic t_code10;
        logic [255:0] b = mk_block(2'b01, 14'b11_11_10_11_11_11_11);
        do_req(b, 4, 0, 0, 0, 2'd0, "R5 pair even local");
        do_req(b, 5, 1, 0, 0, 2'd0, "R5 pair odd call");
        do_req(b, 5, 0, 0, 0, 2'd0, "R5 pair odd local");
    endtask

    task automatic t_code11;
        logic [255:0] b = mk_block(2'b01, 14'b00_00_00_11_00_00_00);
        do_req(b, 6, 0, 0, 1, 2'd3, "R6 none even");
        do_req(b, 7, 1, 0, 1, 2'd3, "R6 none odd call");
    endtask

    task automatic t_odd;
        logic [255:0] b = mk_block(2'b01, 14'b00_01_00_00_00_00_00);
        do_req(b, 1, 0, 0, 0, 2'd2, "R7 odd on any");
        do_req(b, 3, 1, 0, 0, 2'd2, "R7 odd call on local priority");
    endtask

    task automatic t_cw_slot;
        logic [255:0] b = mk_block(2'b01, 14'h0);
        do_req(b, 14, 0, 0, 1, 2'd3, "R8 control slot even");
        do_req(b, 15, 0, 0, 1, 2'd3, "R8 control slot odd");
    endtask

    task automatic t_prev_pair;
        logic [255:0] b = mk_block(2'b01, 14'h3FFF);
        do_req(b, 0,  0, 1, 1, 2'd0, "R9 disabled cw open");
        do_req(b, 0,  0, 1, 0, 2'd3, "R9 disabled cw closed");
    endtask

    task automatic t_policy;
        do_req(mk_block(2'b00, 14'h3FFF), 14, 1, 0, 1, 2'd0, "R10 lead00 open");
        do_req(mk_block(2'b11, 14'h0),    0,  0, 0, 0, 2'd3, "R10 lead11 closed");
        do_req(mk_block(2'b10, 14'h0),    3,  1, 0, 1, 2'd0, "R2 lead10 not cw");
    endtask

    task automatic t_hold;
        do_req(mk_block(2'b01, 14'h0), 1, 0, 0, 0, 2'd2, "R1 hold setup");
        block_in = mk_block(2'b01, 14'h0); tgt_hw = 0; policy_open = 1;
        repeat (3) @(posedge clk);
        #1;
        check(resp_valid == 0, "R1 idle resp_valid", resp_valid, 0);
        check(reason == 2'd2, "R1 idle reason held", reason, 2);
        check(permit == 0, "R1 idle permit held", permit, 0);
    endtask

    task automatic t_sweep;
        logic [255:0] b = mk_block(2'b01, 14'b00_01_10_11_10_01_00);
        for (int hw = 0; hw < 16; hw++) begin
            for (int k = 0; k < 2; k++) begin
                do_req(b, hw, k[0], 0, 1, model(b, hw, k[0], 0, 1), "R2 sweep");
            end
        end
    endtask

    initial begin
        t_reset();
        t_code00();
        t_code01();
        t_code10();
        t_code11();
        t_odd();
        t_cw_slot();
        t_prev_pair();
        t_policy();
        t_hold();
        t_sweep();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule